// File: doc/BRIEF.md
# Signed-Index Bidirectional Shift Unit

This unit shifts a single-width word or a double-width word pair by an amount given as one signed index. The sign of the index picks the direction: zero or positive moves bits toward the most significant end, negative moves them toward the least significant end by the magnitude of the index. Right shifts come in a logical form, which fills with zeros, and an arithmetic form, which fills with the sign of the most significant word. Every variant exists for one word and for a word pair.

No mux-tree barrel shifter is used. The index is decoded into a one-hot power of two, and the operand is multiplied by it. A left shift keeps the low half of the product. A right shift by n multiplies by 2^(2W-n) and keeps the high half. The arithmetic fill is then added by OR-ing a mask taken from the same power of two. Halving a signed or an unsigned value is an index of -1 on the arithmetic or the logical variant. The unit is a two-stage pipeline. It accepts one request per cycle and returns each result two cycles later.

Top module: `shift_unit`

## Requirements
- R1: A request taken with `in_valid` high gives `out_valid` high with its result exactly two clock edges later. Requests may arrive on consecutive cycles. After reset, `out_valid`, `res_hi` and `res_lo` are zero.
- R2: `op` encoding: bit 1 selects double width and bit 0 selects arithmetic. So 2'b00 is single logical, 2'b01 single arithmetic, 2'b10 double logical and 2'b11 double arithmetic. A positive index n shifts left by n and fills the vacated low bits with zeros, in every variant.
- R3: A negative index shifts right by its magnitude. The logical variants fill the vacated high bits with zeros.
- R4: The arithmetic variants fill the vacated high bits of a right shift with copies of the sign bit. For a single word this is `opnd_lo[W-1]`; for a pair it is `opnd_hi[W-1]`.
- R5: A double-width variant treats {`opnd_hi`,`opnd_lo`} as one 2W-bit value. Bits cross the boundary between the two words in both directions, and the result is {`res_hi`,`res_lo`}.
- R6: A single-width variant uses only `opnd_lo` and returns its result on `res_lo`. `opnd_hi` has no effect, and `res_hi` is zero.
- R7: An index of zero returns the operand unchanged in every variant.
- R8: When the index magnitude is equal to or above the operand width (W for single, 2W for double), the result is all zeros. The one exception is an arithmetic right shift, which gives all sign bits. This holds up to the most negative index value.
- R9: An index of -1 halves the value. The arithmetic variant gives the floored signed quotient by two, and the logical variant gives the unsigned quotient by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | Variant: bit 1 double width, bit 0 arithmetic |
| opnd_hi | input | W | High operand word (double width only) |
| opnd_lo | input | W | Low operand word |
| shift_idx | input | IDX_W | Signed shift index, two's complement |
| out_valid | output | 1 | Result present this cycle |
| res_hi | output | W | High result word (zero for single width) |
| res_lo | output | W | Low result word |

## Verification
In any cycle of a continuous stream, the multiply and sign-fill stage works on one request while the decode stage turns the next request's index into a power of two. A wrong stage register or a stale field would therefore mix two requests. The bench provokes this with a run of requests issued on every cycle, with random variants, operands and indices of both signs and large magnitudes, broken now and then by idle gaps. Each result is judged by a scoreboard against a model built from native shift operators, together with the issue-to-result distance of exactly two cycles. Directed cases cover the sign-fill corners and the boundary-crossing corners.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    // bit 1: double width, bit 0: arithmetic fill on right shifts
    typedef enum logic [1:0] {
        SH_SGL_LOG = 2'b00,
        SH_SGL_ARI = 2'b01,
        SH_DBL_LOG = 2'b10,
        SH_DBL_ARI = 2'b11
    } shift_op_e;

    function automatic logic op_is_double(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic op_is_arith(input logic [1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/shift_index_decode.sv
// Turns a signed index into direction plus a one-hot multiplier factor.
// Left by n  : factor 2^n       (zero when n >= DW)
// Right by n : factor 2^(DW-n)  (n clamped to DW, so exponent 0..DW-1)
module shift_index_decode #(
    parameter int DW    = 32,
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic             rshift,
    output logic [DW-1:0]    pow
);
    localparam int DWB = $clog2(DW + 1);
    localparam int CW  = ((DWB > IDX_W) ? DWB : IDX_W) + 1;

    logic [IDX_W-1:0] mag;
    logic [CW-1:0]    mag_x;
    logic [CW-1:0]    mag_c;
    logic [CW-1:0]    expo;
    logic             kill;

    always_comb begin
        rshift = idx[IDX_W-1];
        mag    = rshift ? (~idx + 1'b1) : idx;
        mag_x  = CW'(mag);
        mag_c  = (mag_x >= CW'(DW)) ? CW'(DW) : mag_x;
        kill   = !rshift && (mag_x >= CW'(DW));
        expo   = rshift ? (CW'(DW) - mag_c) : mag_x;
    end

    for (genvar g = 0; g < DW; g++) begin : g_pow
        assign pow[g] = !kill && (expo == CW'(g));
    end

endmodule

// File: rtl/shift_operand_prep.sv
// Builds the 2W-bit multiplicand and the sign-fill flag for each variant.
module shift_operand_prep #(
    parameter int W = 16
) (
    input  logic [1:0]     op,
    input  logic [W-1:0]   opnd_hi,
    input  logic [W-1:0]   opnd_lo,
    output logic [2*W-1:0] x,
    output logic           dbl,
    output logic           fill
);
    import shift_unit_pkg::*;

    logic sign_bit;

    always_comb begin
        dbl      = op_is_double(op);
        sign_bit = dbl ? opnd_hi[W-1] : opnd_lo[W-1];
        fill     = op_is_arith(op) && sign_bit;
        if (dbl) begin
            x = {opnd_hi, opnd_lo};
        end else begin
            // single width: high word ignored, replaced by zero or sign copies
            x = {{W{fill}}, opnd_lo};
        end
    end

endmodule

// File: rtl/shift_mul_core.sv
// Multiplies by the one-hot factor and applies the right-shift correction.
// The fill mask ~(pow-1) covers exactly the top n bits of a right shift by n.
module shift_mul_core #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] pow,
    input  logic          rshift,
    input  logic          fill,
    output logic [DW-1:0] res
);
    logic [2*DW-1:0] prod;
    logic [DW-1:0]   mask;

    always_comb begin
        prod = {{DW{1'b0}}, x} * {{DW{1'b0}}, pow};
        mask = ~(pow - 1'b1);
        if (rshift) begin
            res = prod[2*DW-1:DW] | (fill ? mask : '0);
        end else begin
            res = prod[DW-1:0];
        end
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
    parameter int W     = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic [W-1:0]     opnd_hi,
    input  logic [W-1:0]     opnd_lo,
    input  logic [IDX_W-1:0] shift_idx,
    output logic             out_valid,
    output logic [W-1:0]     res_hi,
    output logic [W-1:0]     res_lo
);
    localparam int DW = 2 * W;

    typedef struct packed {
        logic          valid;
        logic          dbl;
        logic          rshift;
        logic          fill;
        logic [DW-1:0] x;
        logic [DW-1:0] pow;
    } dec_stage_t;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } out_stage_t;

    dec_stage_t s1_d, s1_q;
    out_stage_t s2_d, s2_q;

    logic          dec_rshift;
    logic [DW-1:0] dec_pow;
    logic [DW-1:0] prep_x;
    logic          prep_dbl;
    logic          prep_fill;
    logic [DW-1:0] mul_res;

    shift_index_decode #(.DW(DW), .IDX_W(IDX_W)) u_decode (
        .idx    (shift_idx),
        .rshift (dec_rshift),
        .pow    (dec_pow)
    );

    shift_operand_prep #(.W(W)) u_prep (
        .op      (op),
        .opnd_hi (opnd_hi),
        .opnd_lo (opnd_lo),
        .x       (prep_x),
        .dbl     (prep_dbl),
        .fill    (prep_fill)
    );

    shift_mul_core #(.DW(DW)) u_mul (
        .x      (s1_q.x),
        .pow    (s1_q.pow),
        .rshift (s1_q.rshift),
        .fill   (s1_q.fill),
        .res    (mul_res)
    );

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.dbl    = prep_dbl;
            s1_d.rshift = dec_rshift;
            s1_d.fill   = prep_fill;
            s1_d.x      = prep_x;
            s1_d.pow    = dec_pow;
        end

        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            s2_d.hi = s1_q.dbl ? mul_res[DW-1:W] : '0;
            s2_d.lo = mul_res[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign res_hi    = s2_q.hi;
    assign res_lo    = s2_q.lo;

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R1
    AST_LEFT_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !shift_idx[IDX_W-1] && shift_idx != '0) |-> ##2 !res_lo[0]); // R2
    AST_LOGIC_RIGHT_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.rshift && !s1_q.fill)
        |=> !($past(s1_q.dbl) ? res_hi[W-1] : res_lo[W-1])); // R3
    AST_ARITH_RIGHT_MSB_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.rshift && s1_q.fill)
        |=> ($past(s1_q.dbl) ? res_hi[W-1] : res_lo[W-1])); // R4
    AST_SINGLE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && !s1_q.dbl) |=> (res_hi == '0)); // R6
    AST_ZERO_INDEX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[1] && shift_idx == '0)
        |-> ##2 ({res_hi, res_lo} == $past({opnd_hi, opnd_lo}, 2))); // R7

endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
    import shift_unit_pkg::*;

    localparam int W        = 16;
    localparam int DW       = 2 * W;
    localparam int IDX_W    = 8;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic [DW-1:0] expv;
        int            cyc;
        string         tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       op = 2'b00;
    logic [W-1:0]     opnd_hi = '0;
    logic [W-1:0]     opnd_lo = '0;
    logic [IDX_W-1:0] shift_idx = '0;
    logic             out_valid;
    logic [W-1:0]     res_hi;
    logic [W-1:0]     res_lo;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    item_t sb[$];

    shift_unit #(.W(W), .IDX_W(IDX_W)) u_shift_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .opnd_hi   (opnd_hi),
        .opnd_lo   (opnd_lo),
        .shift_idx (shift_idx),
        .out_valid (out_valid),
        .res_hi    (res_hi),
        .res_lo    (res_lo)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference model built from native shift operators.
    function automatic logic [DW-1:0] model(input logic [1:0] o, input logic [W-1:0] hi,
                                            input logic [W-1:0] lo, input logic [IDX_W-1:0] ix);
        int k;
        int n;
        logic [W-1:0]  s;
        logic [DW-1:0] d;
        k = int'($signed(ix));
        n = (k < 0) ? -k : k;
        if (!o[1]) begin
            if (k >= 0)    s = (n >= W) ? '0 : (lo << n);
            else if (o[0]) s = (n >= W) ? {W{lo[W-1]}} : W'($signed(lo) >>> n);
            else           s = (n >= W) ? '0 : (lo >> n);
            return {{W{1'b0}}, s};
        end
        d = {hi, lo};
        if (k >= 0)    return (n >= DW) ? '0 : (d << n);
        if (o[0])      return (n >= DW) ? {DW{hi[W-1]}} : DW'($signed(d) >>> n);
        return (n >= DW) ? '0 : (d >> n);
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic send(input logic [1:0] o, input logic [W-1:0] hi, input logic [W-1:0] lo,
                        input int ix, input string tag);
        item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        op        = o;
        opnd_hi   = hi;
        opnd_lo   = lo;
        shift_idx = IDX_W'(ix);
        it.expv   = model(o, hi, lo, IDX_W'(ix));
        it.cyc    = cyc;
        it.tag    = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op       = 2'($urandom);
            opnd_hi  = W'($urandom);
            opnd_lo  = W'($urandom);
        end
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected result", {res_hi, res_lo}, 'x);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.tag, " R1 latency"}, DW'(cyc - it.cyc), DW'(2));
                check(it.tag, {res_hi, res_lo}, it.expv);
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", DW'(out_valid), '0);
        check("R1 reset results", {res_hi, res_lo}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R7: zero index passes operand through
        send(SH_SGL_LOG, 16'hdead, 16'h8421, 0, "R7 single log");
        send(SH_SGL_ARI, 16'h1234, 16'hf00f, 0, "R7 single ari");
        send(SH_DBL_LOG, 16'hbeef, 16'h0101, 0, "R7 double log");
        send(SH_DBL_ARI, 16'h8001, 16'h7ffe, 0, "R7 double ari");
        // R2: left shifts, zero fill
        send(SH_SGL_LOG, 16'h0000, 16'h00ff, 4, "R2 single left");
        send(SH_SGL_ARI, 16'h0000, 16'h8001, 15, "R2 single ari left");
        send(SH_DBL_ARI, 16'h00f0, 16'h0f0f, 7, "R2 double left");
        // R5: crossing the word boundary
        send(SH_DBL_LOG, 16'h0000, 16'h8000, 1, "R5 carry up");
        send(SH_DBL_LOG, 16'h0001, 16'h0000, -1, "R5 carry down");
        send(SH_DBL_LOG, 16'h00ab, 16'hcdef, 17, "R5 left past boundary");
        send(SH_DBL_ARI, 16'h8123, 16'h4567, -20, "R5 right past boundary");
        // R3 / R4: right shifts
        send(SH_SGL_LOG, 16'h0000, 16'hf0f0, -4, "R3 single log right");
        send(SH_DBL_LOG, 16'hf000, 16'h000f, -3, "R3 double log right");
        send(SH_SGL_ARI, 16'h0000, 16'h8800, -5, "R4 single ari neg");
        send(SH_SGL_ARI, 16'hffff, 16'h4800, -5, "R4 single ari pos");
        send(SH_DBL_ARI, 16'hc000, 16'h0001, -9, "R4 double ari neg");
        send(SH_DBL_ARI, 16'h7fff, 16'hffff, -31, "R4 double ari pos");
        // R6: high word ignored for single width
        send(SH_SGL_LOG, 16'hffff, 16'h1234, -8, "R6 hi ignored log");
        send(SH_SGL_ARI, 16'hffff, 16'h1234, -8, "R6 hi ignored ari");
        send(SH_SGL_LOG, 16'h5a5a, 16'h0001, 8, "R6 hi ignored left");
        // R8: large magnitudes
        send(SH_SGL_LOG, 16'h0000, 16'hffff, 16, "R8 single left W");
        send(SH_SGL_LOG, 16'h0000, 16'hffff, -16, "R8 single log W");
        send(SH_SGL_ARI, 16'h0000, 16'h8000, -16, "R8 single ari W");
        send(SH_SGL_ARI, 16'h0000, 16'h8000, -128, "R8 single ari min");
        send(SH_DBL_LOG, 16'hffff, 16'hffff, 32, "R8 double left 2W");
        send(SH_DBL_LOG, 16'hffff, 16'hffff, 127, "R8 double left max");
        send(SH_DBL_LOG, 16'hffff, 16'hffff, -32, "R8 double log 2W");
        send(SH_DBL_ARI, 16'h8000, 16'h0000, -32, "R8 double ari 2W");
        send(SH_DBL_ARI, 16'h8000, 16'h0000, -128, "R8 double ari min");
        send(SH_DBL_ARI, 16'h7fff, 16'hffff, -40, "R8 double ari pos");
        // R9: halving with index -1
        send(SH_SGL_ARI, 16'h0000, 16'hfffb, -1, "R9 signed half");
        send(SH_SGL_LOG, 16'h0000, 16'hfffb, -1, "R9 unsigned half");
        send(SH_DBL_ARI, 16'hffff, 16'hfffd, -1, "R9 double signed half");
        send(SH_DBL_LOG, 16'h8000, 16'h0003, -1, "R9 double unsigned half");
        idle(3);

        // R1/R2/R3/R4/R5: back-to-back stream, mixed directions
        for (int i = 0; i < 300; i++) begin
            int ix;
            ix = int'($urandom_range(0, 80)) - 40;
            if (i % 37 == 0) ix = -128;
            if (i % 41 == 0) ix = 127;
            send(2'($urandom), W'($urandom), W'($urandom), ix, "R1 stream");
            if ($urandom_range(0, 9) == 0) idle(1);
        end
        idle(4);
        check("R1 scoreboard drained", DW'(sb.size()), '0);
        summary();
    end

endmodule